// File: doc/BRIEF.md
# UART Transmit Break and Control-Character Inserter

This block sits between the normal transmit data path and a UART bit shifter. It takes characters from the buffer side over a valid/ready handshake and hands them on, one at a time, to the shifter through a single output holding register. It can also take over the transmit path for two out-of-band jobs without losing or reordering the buffer data.

The first job is a line break. A stop command makes the block send a programmed number of break characters. Each break character is presented with a break flag and all-zero data, so the shifter drives every bit low, stop bits included, for one full character time of the configured format. A one-cycle done pulse marks the hand-off of the last break character, after which the line can return to idle. The second job is priority insertion. A single control character, such as a flow-control XON or XOFF, goes out at the next character boundary, ahead of any buffer character still waiting. A character already in the holding register is always finished first.

The block also reports the character length in bit times for the current frame format, which is the length each break character occupies on the line.

Top module: `uart_tx_oob_inserter`

## Requirements
- R1: While reset is held and in the first cycle after it, out_valid, ins_busy and brk_done are all low.
- R2: Buffer characters accepted on in_valid/in_ready leave on out_data in the order they arrived. Data bits at or above the effective data length are cleared. An offered output (out_valid high, out_ready low) keeps out_data and out_brk unchanged until it is accepted.
- R3: char_bits equals 1 + data length + fmt_par + (1 + fmt_stop2). The data length is fmt_dlen clamped to the range 5 to 9. For example, 8 data bits with no parity and one stop bit give 10.
- R4: A stop_cmd pulse seen while no break is running samples brk_count and sends exactly that many break characters, each with out_brk=1 and out_data=0. Buffer data is held off (in_ready low) while break characters remain, and none of it is lost.
- R5: A stop_cmd with brk_count=0 sends no break character and raises brk_done in the next cycle.
- R6: brk_done is a one-cycle pulse in the cycle after the last break character is accepted, and it is raised once per break sequence.
- R7: A stop_cmd that arrives while a break sequence is running is ignored, including its brk_count value.
- R8: An ins_req taken while ins_busy is low stores ins_char, masked to the data length like buffer data. The stored character is the next character offered after the one already in the holding register, ahead of any waiting buffer character.
- R9: ins_busy is high from the cycle after an insert is taken until the stored character moves into the holding register. An ins_req while ins_busy is high is dropped and never transmitted.
- R10: Pending break characters take priority over a pending insert, so an insert requested during a break goes out right after the last break character.
- R11: While ins_busy is high, in_ready is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Buffer character offered |
| in_data | input | DW | Buffer character, LSB first on the line |
| in_ready | output | 1 | Buffer character accepted this cycle |
| stop_cmd | input | 1 | One-cycle stop-transmit command that starts a break |
| brk_count | input | CW | Number of break characters, sampled with stop_cmd |
| brk_done | output | 1 | One-cycle pulse when the break sequence ends |
| ins_req | input | 1 | Request to insert a control character |
| ins_char | input | DW | Control character to insert |
| ins_busy | output | 1 | An inserted character is still pending |
| fmt_dlen | input | LW | Data bits per character (5 to 9, clamped) |
| fmt_par | input | 1 | Parity bit present |
| fmt_stop2 | input | 1 | Two stop bits when high, one when low |
| out_valid | output | 1 | Character offered to the shifter |
| out_data | output | DW | Character data to the shifter |
| out_brk | output | 1 | Offered character is a break character |
| out_ready | input | 1 | Shifter takes the offered character |
| char_bits | output | BW | Character length in bit times |

## Verification
The scoreboard is fed from several patterns. A plain buffer stream with the shifter ready, and another with the shifter ready only every other cycle, separate correct ordering from problems with holding and back-pressure. An insert made while a buffer character sits stalled in the holding register, with more buffer data queued, shows whether the insert jumps the queue without displacing the held character. A second insert attempt while busy shows that overwrites are dropped. Break runs with counts of three, zero, and two with a later stop command of five test exact counting, the empty case and re-trigger immunity. A break with an insert made during it tests break-over-insert priority. Format sweeps, including out-of-range data lengths, test both the length formula and data masking.

// File: rtl/uart_txo_pkg.sv
// Shared definitions for the UART transmit out-of-band inserter.
// Assumes: a single clock domain; all users import this package.
package uart_txo_pkg;

    // Shortest data length a character may have; shorter settings are raised to it.
    localparam int TXO_MIN_DLEN = 5;

    // Source chosen for the next character loaded into the holding register.
    typedef enum logic [1:0] {
        SRC_NONE = 2'd0,
        SRC_BRK  = 2'd1,
        SRC_INS  = 2'd2,
        SRC_DAT  = 2'd3
    } txo_src_e;

endpackage

// File: rtl/uart_txo_fmt.sv
// Frame format decoder.
// Clamps the requested data length to [TXO_MIN_DLEN, DW], builds a mask of the
// valid data bits and computes the character length in bit times:
// start + data + optional parity + one or two stop bits.
// Assumes: DW >= TXO_MIN_DLEN; purely combinational.
module uart_txo_fmt
    import uart_txo_pkg::*;
#(
    parameter int DW = 9,
    parameter int LW = $clog2(DW + 1),
    parameter int BW = $clog2(DW + 5)
) (
    input  logic [LW-1:0] dlen_raw,
    input  logic          par_en,
    input  logic          stop2,
    output logic [DW-1:0] mask,
    output logic [BW-1:0] char_bits
);

    localparam logic [LW-1:0] DL_MIN = LW'(TXO_MIN_DLEN);
    localparam logic [LW-1:0] DL_MAX = LW'(DW);

    logic [LW-1:0] dlen_eff;

    // Clamp the data length into the supported range.
    always_comb begin
        if (dlen_raw < DL_MIN) begin
            dlen_eff = DL_MIN;
        end else if (dlen_raw > DL_MAX) begin
            dlen_eff = DL_MAX;
        end else begin
            dlen_eff = dlen_raw;
        end
    end

    // One mask bit per data position, set when the position is below the length.
    for (genvar gi = 0; gi < DW; gi++) begin : g_mask
        assign mask[gi] = (LW'(gi) < dlen_eff);
    end

    // Character length: one start bit, data, parity, one stop bit plus optional second.
    always_comb begin
        char_bits = BW'(2) + BW'(dlen_eff) + BW'(par_en) + BW'(stop2);
    end

endmodule

// File: rtl/uart_txo_brkseq.sv
// Break sequencer.
// Samples the break count on a stop command while idle, requests one break
// character per count, and pulses done one cycle after the last break
// character is accepted downstream. A zero count pulses done directly.
// Assumes: stop_cmd is ignored while a sequence is running; brk_take only
// occurs while brk_want is high.
module uart_txo_brkseq #(
    parameter int CW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          stop_cmd,
    input  logic [CW-1:0] brk_count,
    input  logic          brk_take,
    input  logic          brk_hs,
    output logic          brk_want,
    output logic          brk_run,
    output logic          brk_done
);

    logic [CW-1:0] remain;

    // Break characters are still owed while running with a nonzero remainder.
    always_comb begin
        brk_want = brk_run && (remain != '0);
    end

    // Sequence control: start, count down per break taken, finish on last hand-off.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            brk_run  <= 1'b0;
            remain   <= '0;
            brk_done <= 1'b0;
        end else begin
            brk_done <= 1'b0;
            if (!brk_run) begin
                if (stop_cmd) begin
                    if (brk_count == '0) begin
                        brk_done <= 1'b1;
                    end else begin
                        brk_run <= 1'b1;
                        remain  <= brk_count;
                    end
                end
            end else begin
                if (brk_take) begin
                    remain <= remain - CW'(1);
                end
                if ((remain == '0) && brk_hs) begin
                    brk_run  <= 1'b0;
                    brk_done <= 1'b1;
                end
            end
        end
    end

endmodule

// File: rtl/uart_txo_insslot.sv
// Single-entry store for an out-of-sequence control character.
// Takes a request only when empty and keeps the character until the arbiter
// moves it into the holding register. Requests while full are dropped.
// Assumes: ins_take only occurs while ins_pend is high.
module uart_txo_insslot #(
    parameter int DW = 9
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          ins_req,
    input  logic [DW-1:0] ins_char,
    input  logic          ins_take,
    output logic          ins_pend,
    output logic [DW-1:0] ins_data
);

    // Fill on a request when empty; empty when the character is taken.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ins_pend <= 1'b0;
            ins_data <= '0;
        end else if (!ins_pend) begin
            if (ins_req) begin
                ins_pend <= 1'b1;
                ins_data <= ins_char;
            end
        end else if (ins_take) begin
            ins_pend <= 1'b0;
        end
    end

endmodule

// File: rtl/uart_txo_arb.sv
// Output arbiter with a single holding register toward the shifter.
// At each character boundary (register empty or being accepted) it loads, in
// priority order: a break character, the pending inserted character, or the
// next buffer character. Data is masked to the active data length on load.
// Assumes: the shifter follows valid/ready; the held character never changes
// while it is offered.
module uart_txo_arb
    import uart_txo_pkg::*;
#(
    parameter int DW = 9
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          brk_want,
    input  logic          ins_pend,
    input  logic [DW-1:0] ins_data,
    input  logic          in_valid,
    input  logic [DW-1:0] in_data,
    input  logic [DW-1:0] mask,
    input  logic          out_ready,
    output logic          in_ready,
    output logic          brk_take,
    output logic          ins_take,
    output logic          brk_hs,
    output logic          out_valid,
    output logic [DW-1:0] out_data,
    output logic          out_brk
);

    txo_src_e sel;
    logic     load;
    logic     hs;

    // Boundary detection: register free now or freed by this acceptance.
    always_comb begin
        hs   = out_valid && out_ready;
        load = !out_valid || out_ready;
    end

    // Priority choice of the next source.
    always_comb begin
        if (brk_want) begin
            sel = SRC_BRK;
        end else if (ins_pend) begin
            sel = SRC_INS;
        end else if (in_valid) begin
            sel = SRC_DAT;
        end else begin
            sel = SRC_NONE;
        end
    end

    // Handshake strobes back to the sources.
    always_comb begin
        in_ready = load && !brk_want && !ins_pend;
        brk_take = load && (sel == SRC_BRK);
        ins_take = load && (sel == SRC_INS);
        brk_hs   = hs && out_brk;
    end

    // Holding register toward the shifter.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            out_data  <= '0;
            out_brk   <= 1'b0;
        end else if (load) begin
            case (sel)
                SRC_BRK: begin
                    out_valid <= 1'b1;
                    out_data  <= '0;
                    out_brk   <= 1'b1;
                end
                SRC_INS: begin
                    out_valid <= 1'b1;
                    out_data  <= ins_data & mask;
                    out_brk   <= 1'b0;
                end
                SRC_DAT: begin
                    out_valid <= 1'b1;
                    out_data  <= in_data & mask;
                    out_brk   <= 1'b0;
                end
                default: begin
                    out_valid <= 1'b0;
                    out_brk   <= 1'b0;
                end
            endcase
        end
    end

endmodule

// File: rtl/uart_tx_oob_inserter.sv
// UART transmit break and control-character inserter (top).
// Feeds a bit shifter one character at a time and, on request, replaces the
// buffer stream with a counted run of all-zero break characters or slips a
// single control character in at the next character boundary.
// Assumes: stop_cmd and ins_req are sampled on each rising clock edge; the
// shifter consumes characters through out_valid/out_ready.
module uart_tx_oob_inserter
    import uart_txo_pkg::*;
#(
    parameter  int DW = 9,
    parameter  int CW = 16,
    localparam int LW = $clog2(DW + 1),
    localparam int BW = $clog2(DW + 5)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          in_valid,
    input  logic [DW-1:0] in_data,
    output logic          in_ready,
    input  logic          stop_cmd,
    input  logic [CW-1:0] brk_count,
    output logic          brk_done,
    input  logic          ins_req,
    input  logic [DW-1:0] ins_char,
    output logic          ins_busy,
    input  logic [LW-1:0] fmt_dlen,
    input  logic          fmt_par,
    input  logic          fmt_stop2,
    output logic          out_valid,
    output logic [DW-1:0] out_data,
    output logic          out_brk,
    input  logic          out_ready,
    output logic [BW-1:0] char_bits
);

    logic [DW-1:0] mask;
    logic          brk_want;
    logic          brk_run;
    logic          brk_take;
    logic          brk_hs;
    logic          ins_pend;
    logic          ins_take;
    logic [DW-1:0] ins_data;

    uart_txo_fmt #(.DW(DW), .LW(LW), .BW(BW)) u_fmt (
        .dlen_raw  (fmt_dlen),
        .par_en    (fmt_par),
        .stop2     (fmt_stop2),
        .mask      (mask),
        .char_bits (char_bits)
    );

    uart_txo_brkseq #(.CW(CW)) u_brk (
        .clk       (clk),
        .rst_n     (rst_n),
        .stop_cmd  (stop_cmd),
        .brk_count (brk_count),
        .brk_take  (brk_take),
        .brk_hs    (brk_hs),
        .brk_want  (brk_want),
        .brk_run   (brk_run),
        .brk_done  (brk_done)
    );

    uart_txo_insslot #(.DW(DW)) u_ins (
        .clk      (clk),
        .rst_n    (rst_n),
        .ins_req  (ins_req),
        .ins_char (ins_char),
        .ins_take (ins_take),
        .ins_pend (ins_pend),
        .ins_data (ins_data)
    );

    uart_txo_arb #(.DW(DW)) u_arb (
        .clk       (clk),
        .rst_n     (rst_n),
        .brk_want  (brk_want),
        .ins_pend  (ins_pend),
        .ins_data  (ins_data),
        .in_valid  (in_valid),
        .in_data   (in_data),
        .mask      (mask),
        .out_ready (out_ready),
        .in_ready  (in_ready),
        .brk_take  (brk_take),
        .ins_take  (ins_take),
        .brk_hs    (brk_hs),
        .out_valid (out_valid),
        .out_data  (out_data),
        .out_brk   (out_brk)
    );

    // Busy reflects the insert store occupancy.
    always_comb begin
        ins_busy = ins_pend;
    end

endmodule

// File: rtl/uart_txo_chk.sv
// Property checker for the transmit out-of-band inserter, bound to the top.
// Assumes: observes ports plus the break-running state of the sequencer.
module uart_txo_chk #(
    parameter int DW = 9,
    parameter int BW = 4
) (
    input logic          clk,
    input logic          rst_n,
    input logic          in_ready,
    input logic          stop_cmd,
    input logic          brk_done,
    input logic          ins_busy,
    input logic          out_valid,
    input logic [DW-1:0] out_data,
    input logic          out_brk,
    input logic          out_ready,
    input logic [BW-1:0] char_bits,
    input logic          brk_run
);

    // R2
    hold_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_data) && $stable(out_brk)));

    // R4
    brk_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_brk) |-> (out_data == '0));

    // R6
    done_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        brk_done |-> ($past(stop_cmd) || $past(out_valid && out_ready && out_brk)));

    // R6
    done_ends_run_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (brk_done && !$past(stop_cmd)) |-> !brk_run);

    // R9
    ins_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ins_busy && out_valid && !out_ready) |=> ins_busy);

    // R11
    ins_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ins_busy |-> !in_ready);

    // R3
    len_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (char_bits >= BW'(7)) && (char_bits <= BW'(DW + 4)));

endmodule

bind uart_tx_oob_inserter uart_txo_chk #(.DW(DW), .BW(BW)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_ready  (in_ready),
    .stop_cmd  (stop_cmd),
    .brk_done  (brk_done),
    .ins_busy  (ins_busy),
    .out_valid (out_valid),
    .out_data  (out_data),
    .out_brk   (out_brk),
    .out_ready (out_ready),
    .char_bits (char_bits),
    .brk_run   (brk_run)
);

// File: tb/uart_tx_oob_inserter_test.sv
`timescale 1ns/1ps
module uart_tx_oob_inserter_test;

    localparam int DW = 9;
    localparam int CW = 16;
    localparam int LW = $clog2(DW + 1);
    localparam int BW = $clog2(DW + 5);

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          in_valid = 1'b0;
    logic [DW-1:0] in_data = '0;
    logic          in_ready;
    logic          stop_cmd = 1'b0;
    logic [CW-1:0] brk_count = '0;
    logic          brk_done;
    logic          ins_req = 1'b0;
    logic [DW-1:0] ins_char = '0;
    logic          ins_busy;
    logic [LW-1:0] fmt_dlen = LW'(8);
    logic          fmt_par = 1'b0;
    logic          fmt_stop2 = 1'b0;
    logic          out_valid;
    logic [DW-1:0] out_data;
    logic          out_brk;
    logic          out_ready = 1'b0;
    logic [BW-1:0] char_bits;

    int total = 0;
    int bad = 0;
    int done_cnt = 0;
    bit finished = 0;

    logic [DW-1:0] src_q[$];
    logic [DW:0]   exp_q[$];
    string         tag_q[$];
    bit            src_hs = 0;

    always #10 clk = ~clk;

    uart_tx_oob_inserter #(.DW(DW), .CW(CW)) uut (.*);

    task automatic check(input string tag, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
        end
    endtask

    // Driver side: queue a buffer character and its expected output.
    task automatic send(input logic [DW-1:0] d, input logic [DW-1:0] e, input string tag);
        src_q.push_back(d);
        exp_q.push_back({1'b0, e});
        tag_q.push_back(tag);
    endtask

    task automatic expect_brk(input int n, input string tag);
        for (int i = 0; i < n; i++) begin
            exp_q.push_back({1'b1, {DW{1'b0}}});
            tag_q.push_back(tag);
        end
    endtask

    task automatic expect_chr(input logic [DW-1:0] e, input string tag);
        exp_q.push_back({1'b0, e});
        tag_q.push_back(tag);
    endtask

    task automatic stop_pulse(input int cnt);
        brk_count = CW'(cnt);
        stop_cmd  = 1'b1;
        @(negedge clk);
        stop_cmd  = 1'b0;
    endtask

    task automatic insert(input logic [DW-1:0] c);
        ins_req  = 1'b1;
        ins_char = c;
        @(negedge clk);
        ins_req  = 1'b0;
    endtask

    task automatic drain(input string tag);
        for (int i = 0; i < 200 && exp_q.size() != 0; i++) @(negedge clk);
        repeat (3) @(negedge clk);
        #3;
        check(tag, exp_q.size(), 0);
    endtask

    // Buffer source: presents the queue head, pops after an accepted handshake.
    always @(negedge clk) begin
        if (src_hs && src_q.size() != 0) void'(src_q.pop_front());
        in_valid = (src_q.size() != 0);
        in_data  = (src_q.size() != 0) ? src_q[0] : '0;
        #1;
        src_hs = rst_n && in_valid && in_ready;
    end

    // Monitor: compares every accepted output against the scoreboard.
    always @(negedge clk) begin
        #2;
        if (rst_n && out_valid && out_ready) begin
            if (exp_q.size() == 0) begin
                total++;
                bad++;
                $display("FAIL unexpected output act=%0h exp=none", {out_brk, out_data});
            end else begin
                logic [DW:0] e;
                string t;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                check(t, int'({out_brk, out_data}), int'(e));
            end
        end
        if (rst_n && brk_done) done_cnt++;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            total++;
            bad++;
            $display("FAIL watchdog act=hung exp=finish");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        int d0;
        repeat (3) @(negedge clk);
        #3;
        // R1 state during reset
        check("R1 out_valid in reset", out_valid, 0);
        check("R1 ins_busy in reset", ins_busy, 0);
        rst_n = 1'b1;
        @(negedge clk);
        #3;
        check("R1 out_valid after reset", out_valid, 0);
        check("R1 brk_done after reset", brk_done, 0);

        // R3 format sweep
        fmt_dlen = LW'(8); fmt_par = 0; fmt_stop2 = 0; #1;
        check("R3 8N1 length", char_bits, 10);
        fmt_dlen = LW'(8); fmt_par = 1; fmt_stop2 = 1; #1;
        check("R3 8P2 length", char_bits, 12);
        fmt_dlen = LW'(5); fmt_par = 0; fmt_stop2 = 0; #1;
        check("R3 5N1 length", char_bits, 7);
        fmt_dlen = LW'(9); fmt_par = 1; fmt_stop2 = 1; #1;
        check("R3 9P2 length", char_bits, 13);
        fmt_dlen = LW'(3); fmt_par = 0; fmt_stop2 = 0; #1;
        check("R3 clamp low", char_bits, 7);
        fmt_dlen = LW'(15); fmt_par = 0; fmt_stop2 = 1; #1;
        check("R3 clamp high", char_bits, 12);
        fmt_dlen = LW'(8); fmt_par = 0; fmt_stop2 = 0;
        @(negedge clk);

        // R2 plain stream, shifter always ready
        out_ready = 1'b1;
        send(9'h055, 9'h055, "R2 stream");
        send(9'h1A3, 9'h0A3, "R2 stream mask");
        send(9'h0FF, 9'h0FF, "R2 stream");
        send(9'h000, 9'h000, "R2 stream");
        drain("R2 stream drained");

        // R2 stream with shifter ready every other cycle
        for (int i = 0; i < 6; i++) send(DW'(i * 37 + 1), DW'(i * 37 + 1) & 9'h0FF, "R2 bursty");
        for (int i = 0; i < 16; i++) begin
            out_ready = i[0];
            @(negedge clk);
        end
        out_ready = 1'b1;
        drain("R2 bursty drained");

        // R2 masking at 5 data bits and with a clamped length
        fmt_dlen = LW'(5);
        send(9'h1FF, 9'h01F, "R2 mask 5 bits");
        drain("R2 mask drained");
        insert(9'h0AA);
        expect_chr(9'h00A, "R8 insert masked");
        drain("R8 insert mask drained");
        fmt_dlen = LW'(3);
        send(9'h0FF, 9'h01F, "R2 mask clamp");
        drain("R2 clamp drained");
        fmt_dlen = LW'(8);

        // R8 insert jumps queued data, held character finishes first
        out_ready = 1'b0;
        send(9'h041, 9'h041, "R8 held first");
        send(9'h042, 9'h042, "R8 after insert");
        send(9'h043, 9'h043, "R8 after insert");
        repeat (3) @(negedge clk);
        expect_chr(9'h011, "R8 insert order");
        // reorder expected: held A, insert, then B, C
        exp_q.delete(exp_q.size() - 1);
        tag_q.delete(tag_q.size() - 1);
        exp_q.insert(1, {1'b0, 9'h011});
        tag_q.insert(1, "R8 insert order");
        insert(9'h011);
        #1;
        check("R9 busy after insert", ins_busy, 1);
        check("R11 in_ready low while busy", in_ready, 0);
        out_ready = 1'b1;
        drain("R8 insert drained");
        check("R9 busy cleared", ins_busy, 0);

        // R9 second request while busy is dropped
        out_ready = 1'b0;
        send(9'h061, 9'h061, "R9 held");
        repeat (2) @(negedge clk);
        expect_chr(9'h013, "R9 first insert");
        insert(9'h013);
        insert(9'h019);
        #1;
        check("R9 busy held", ins_busy, 1);
        out_ready = 1'b1;
        drain("R9 drained");
        #1;
        check("R9 dropped request no output", out_valid, 0);

        // R4 break of three, data queued behind it
        d0 = done_cnt;
        expect_brk(3, "R4 break char");
        stop_pulse(3);
        send(9'h0C3, 9'h0C3, "R4 data after break");
        #1;
        check("R4 in_ready low during break", in_ready, 0);
        drain("R4 drained");
        check("R6 one done pulse", done_cnt - d0, 1);

        // R5 zero count
        d0 = done_cnt;
        stop_pulse(0);
        #3;
        check("R5 done next cycle", brk_done, 1);
        @(negedge clk);
        #3;
        check("R6 done single cycle", brk_done, 0);
        send(9'h0D5, 9'h0D5, "R5 data passes");
        drain("R5 drained");
        check("R5 one done pulse", done_cnt - d0, 1);

        // R7 stop during break ignored
        d0 = done_cnt;
        expect_brk(2, "R7 break char");
        stop_pulse(2);
        stop_pulse(5);
        drain("R7 drained");
        check("R7 one done pulse", done_cnt - d0, 1);

        // R10 insert during break follows the breaks
        d0 = done_cnt;
        out_ready = 1'b0;
        expect_brk(2, "R10 break char");
        expect_chr(9'h013, "R10 insert after break");
        stop_pulse(2);
        repeat (2) @(negedge clk);
        insert(9'h013);
        out_ready = 1'b1;
        drain("R10 drained");
        check("R10 done pulse", done_cnt - d0, 1);

        finished = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule